// File: doc/BRIEF.md
# Single-Pin GPIO Cell with Event Detection

This block controls one general-purpose I/O pad. Software programs it through a small word-addressed register port. It decides whether the pin is active and whether it drives. It can release the pad while still in output mode, and it sets the level driven out. Software can read back the pad level after synchronization and optional filtering.

The qualified input level feeds an event detector. The detector can watch a level, one chosen edge, or both edges. A polarity bit selects active-high or rising versus active-low or falling. A detected event sets a sticky pending flag, which software clears by a write. The interrupt output is that flag, gated by an interrupt enable bit and by the pin enable bit.

An optional debounce filter counts a free-running millisecond tick. It accepts a new input level only after the level has held for a programmed number of ticks.

Top module: `gpio_pin_unit`

## Requirements
- R1: After synchronous reset every register reads zero, `pad_oe` is 0 and `irq` is 0.
- R2: Register offsets are: 0x00 configuration (bits 6:0), 0x04 debounce threshold (bits 7:0), 0x08 input level (bit 0), 0x0C release-pad flag (bit 0), 0x10 drive level (bit 0), 0x14 pending (bit 0, read) / clear (write). A written field reads back unchanged, and unused bits read zero.
- R3: `pad_oe` is 1 exactly when configuration bit 0 (enable) is 1, bit 1 (output) is 1 and the release-pad flag is 0. `pad_out` follows the drive-level bit.
- R4: With the filter bypassed, a pad change first appears in the input register after the third rising clock edge. This is two synchronizer stages plus one qualify stage.
- R5: With configuration bit 5 set and a nonzero threshold N, a changed level is accepted only on the Nth millisecond tick during which it has stayed changed. A change that lasts fewer ticks is ignored.
- R6: A threshold of 0 bypasses the filter even when bit 5 is set, giving the R4 latency.
- R7: Trigger type bits 3:2 = 01 select level mode. Bit 4 = 1 pends while the level is high; bit 4 = 0 pends while the level is low.
- R8: Type 10 selects single-edge mode. Bit 4 = 1 pends on a rising edge only; bit 4 = 0 pends on a falling edge only.
- R9: Type 11 pends on either edge, whatever the value of bit 4.
- R10: Type 00 never sets the pending flag.
- R11: Writing 1 in bit 0 to offset 0x14 clears the pending flag. If a detected event (including a still-active level) occurs in the same cycle as the clear, the flag stays set.
- R12: `irq` equals pending AND configuration bit 6 AND bit 0. Clearing bit 6 masks `irq` but keeps the pending flag.
- R13: A pin with bit 0 = 0 drives nothing and sets no pending flag on input activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| pad_in | input | 1 | Level seen at the pad |
| pad_out | output | 1 | Level driven onto the pad |
| pad_oe | output | 1 | Pad driver enable |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a clear write that lands in the same clock edge as a fresh edge event. The pad change must travel through three register stages, so the write has to be placed on exactly the fourth edge after the pad is driven. The bench first leaves an earlier event pending, counts the edges, and issues the clear on that edge; the flag must then read back set. The debounce glitch case is also hard to reach, because the flag must only be judged after a counted tick sequence. The bench aborts one change after two of three ticks, then repeats the change with a full third tick.

// File: rtl/pin_unit_pkg.sv
package pin_unit_pkg;

    parameter int ADDR_W = 5;
    parameter int DATA_W = 32;
    parameter int THR_W  = 8;

    localparam logic [ADDR_W-1:0] OFS_CFG   = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_THR   = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_LEVEL = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_HIZ   = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_DRIVE = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_PEND  = 5'h14;

    typedef enum logic [1:0] {
        TRIG_OFF   = 2'b00,
        TRIG_LEVEL = 2'b01,
        TRIG_EDGE  = 2'b10,
        TRIG_BOTH  = 2'b11
    } trig_e;

    // Field order fixes the bit positions: pin_on is bit 0, irq_on is bit 6.
    typedef struct packed {
        logic  irq_on;
        logic  filt_on;
        logic  hi_rise;
        trig_e trig;
        logic  drive_dir;
        logic  pin_on;
    } pin_cfg_t;

    localparam int CFG_W = $bits(pin_cfg_t);

    function automatic logic event_hit(trig_e t, logic hi_rise, logic cur, logic prv);
        logic rise;
        logic fall;
        rise = cur & ~prv;
        fall = ~cur & prv;
        case (t)
            TRIG_LEVEL: event_hit = (cur == hi_rise);
            TRIG_EDGE:  event_hit = hi_rise ? rise : fall;
            TRIG_BOTH:  event_hit = rise | fall;
            default:    event_hit = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/pin_regs.sv
module pin_regs
    import pin_unit_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              level_in,
    input  logic              pend_in,
    output pin_cfg_t          cfg,
    output logic [THR_W-1:0]  thr,
    output logic              hiz,
    output logic              drive_lvl,
    output logic              clr_pulse
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg       <= '0;
            thr       <= '0;
            hiz       <= 1'b0;
            drive_lvl <= 1'b0;
        end else if (wr) begin
            case (addr)
                OFS_CFG:   cfg       <= pin_cfg_t'(wdata[CFG_W-1:0]);
                OFS_THR:   thr       <= wdata[THR_W-1:0];
                OFS_HIZ:   hiz       <= wdata[0];
                OFS_DRIVE: drive_lvl <= wdata[0];
                default: ;
            endcase
        end
    end

    assign clr_pulse = wr && (addr == OFS_PEND) && wdata[0];

    always_comb begin
        rdata = '0;
        case (addr)
            OFS_CFG:   rdata[CFG_W-1:0] = cfg;
            OFS_THR:   rdata[THR_W-1:0] = thr;
            OFS_LEVEL: rdata[0]         = level_in;
            OFS_HIZ:   rdata[0]         = hiz;
            OFS_DRIVE: rdata[0]         = drive_lvl;
            OFS_PEND:  rdata[0]         = pend_in;
            default: ;
        endcase
    end

endmodule

// File: rtl/pin_in_filter.sv
module pin_in_filter
    import pin_unit_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pad_in,
    input  logic             filt_on,
    input  logic [THR_W-1:0] thr,
    input  logic             tick,
    output logic             lvl
);

    localparam int CNT_W = THR_W + 1;

    logic [SYNC_STAGES-1:0] chain;
    logic [THR_W-1:0]       cnt;
    logic                   sync_lvl;
    logic                   bypass;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= pad_in;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[SYNC_STAGES-2:0], pad_in};
            end
        end
    endgenerate

    assign sync_lvl = chain[SYNC_STAGES-1];
    assign bypass   = !filt_on || (thr == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl <= 1'b0;
            cnt <= '0;
        end else if (bypass) begin
            lvl <= sync_lvl;
            cnt <= '0;
        end else if (sync_lvl == lvl) begin
            cnt <= '0;
        end else if (tick) begin
            if (CNT_W'(cnt) + CNT_W'(1) >= CNT_W'(thr)) begin
                lvl <= sync_lvl;
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R5: with the filter active the qualified level moves only on a tick edge
    a_r5_change_on_tick: assert property (@(posedge clk) disable iff (rst)
        ($past(!bypass) && (lvl != $past(lvl))) |-> $past(tick));

    // R4: any new qualified level is the synchronized pad level
    a_r4_from_sync: assert property (@(posedge clk) disable iff (rst)
        (lvl != $past(lvl)) |-> (lvl == $past(sync_lvl)));

endmodule

// File: rtl/pin_event.sv
module pin_event
    import pin_unit_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  pin_on,
    input  trig_e trig,
    input  logic  hi_rise,
    input  logic  lvl,
    input  logic  clr,
    output logic  pend
);

    logic prv;
    logic hit;

    assign hit = pin_on && event_hit(trig, hi_rise, lvl, prv);

    always_ff @(posedge clk) begin
        if (rst) begin
            prv  <= 1'b0;
            pend <= 1'b0;
        end else begin
            prv  <= lvl;
            pend <= hit | (pend & ~clr);
        end
    end

    // R13: the flag can only rise while the pin is enabled
    a_r13_rise_needs_enable: assert property (@(posedge clk) disable iff (rst)
        $rose(pend) |-> $past(pin_on));

    // R7: an active level in level mode always leaves the flag set
    a_r7_level_pends: assert property (@(posedge clk) disable iff (rst)
        (pin_on && trig == TRIG_LEVEL && lvl == hi_rise) |=> pend);

    // R10: type none never sets the flag
    a_r10_none_quiet: assert property (@(posedge clk) disable iff (rst)
        (trig == TRIG_OFF && !pend) |=> !pend);

endmodule

// File: rtl/gpio_pin_unit.sv
module gpio_pin_unit
    import pin_unit_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              pad_in,
    output logic              pad_out,
    output logic              pad_oe,
    input  logic              ms_tick,
    output logic              irq
);

    pin_cfg_t         cfg;
    logic [THR_W-1:0] thr;
    logic             hiz;
    logic             drive_lvl;
    logic             clr_pulse;
    logic             lvl;
    logic             pend;

    pin_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr        (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .level_in  (lvl),
        .pend_in   (pend),
        .cfg       (cfg),
        .thr       (thr),
        .hiz       (hiz),
        .drive_lvl (drive_lvl),
        .clr_pulse (clr_pulse)
    );

    pin_in_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filter (
        .clk     (clk),
        .rst     (rst),
        .pad_in  (pad_in),
        .filt_on (cfg.filt_on),
        .thr     (thr),
        .tick    (ms_tick),
        .lvl     (lvl)
    );

    pin_event u_event (
        .clk     (clk),
        .rst     (rst),
        .pin_on  (cfg.pin_on),
        .trig    (cfg.trig),
        .hi_rise (cfg.hi_rise),
        .lvl     (lvl),
        .clr     (clr_pulse),
        .pend    (pend)
    );

    assign pad_out = drive_lvl;
    assign pad_oe  = cfg.pin_on & cfg.drive_dir & ~hiz;
    assign irq     = pend & cfg.irq_on & cfg.pin_on;

    // R12: a request is never raised without a pending event behind it
    a_r12_irq_has_pend: assert property (@(posedge clk) disable iff (rst)
        irq |-> pend);

    // R3: a released pad is never driven
    a_r3_hiz_no_drive: assert property (@(posedge clk) disable iff (rst)
        hiz |-> !pad_oe);

    // R11: a clear with no new event leaves the flag low
    a_r11_clear_wins_alone: assert property (@(posedge clk) disable iff (rst)
        (clr_pulse && !cfg.pin_on) |=> !pend);

endmodule

// File: tb/gpio_pin_unit_bench.sv
module gpio_pin_unit_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pad_in = 1'b0;
    logic        pad_out;
    logic        pad_oe;
    logic        ms_tick = 1'b0;
    logic        irq;

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;

    typedef struct {
        string       req;
        int          sel;
        logic [31:0] exp;
    } item_t;

    item_t sb_q[$];
    event  cmp_ev;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_pin_unit u_gpio_pin_unit (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .ms_tick   (ms_tick),
        .irq       (irq)
    );

    // monitor: pops expected items and compares with the live outputs
    always @(cmp_ev) begin
        while (sb_q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb_q.pop_front();
            case (it.sel)
                0: act = {31'b0, irq};
                1: act = {31'b0, pad_oe};
                2: act = {31'b0, pad_out};
                default: act = reg_rdata;
            endcase
            compared++;
            if (act !== it.exp) begin
                mismatched++;
                $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
            end
        end
    end

    task automatic push(int sel, logic [31:0] exp, string req);
        item_t it;
        it.req = req; it.sel = sel; it.exp = exp;
        sb_q.push_back(it);
        -> cmp_ev;
        #1;
    endtask

    task automatic chk_irq(logic e, string req);  #1; push(0, {31'b0, e}, req); endtask
    task automatic chk_oe(logic e, string req);   #1; push(1, {31'b0, e}, req); endtask
    task automatic chk_out(logic e, string req);  #1; push(2, {31'b0, e}, req); endtask
    task automatic chk_rd(logic [4:0] a, logic [31:0] e, string req);
        reg_addr = a; #1; push(3, e, req);
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic set_pad(logic v);
        @(negedge clk); pad_in = v;
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic tick();
        @(negedge clk); ms_tick = 1'b1;
        @(negedge clk); ms_tick = 1'b0;
    endtask

    task automatic clr();
        wr(5'h14, 32'h1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog: actual running expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk_irq(1'b0, "R1 irq");
        chk_oe(1'b0, "R1 pad_oe");
        chk_rd(5'h00, 32'h0, "R1 cfg");
        chk_rd(5'h04, 32'h0, "R1 thr");
        chk_rd(5'h0C, 32'h0, "R1 hiz");
        chk_rd(5'h10, 32'h0, "R1 drive");

        // R2 readback with unused bits dropped
        wr(5'h00, 32'hFFFF_FF5A);
        chk_rd(5'h00, 32'h5A, "R2 cfg");
        wr(5'h04, 32'h1FF);
        chk_rd(5'h04, 32'hFF, "R2 thr");
        wr(5'h0C, 32'hFFFF_FFFF);
        chk_rd(5'h0C, 32'h1, "R2 hiz");
        wr(5'h00, 32'h0); wr(5'h04, 32'h0); wr(5'h0C, 32'h0);

        // R3 drive control
        wr(5'h10, 32'h1);
        wr(5'h00, 32'h03);
        chk_oe(1'b1, "R3 oe on");
        chk_out(1'b1, "R3 out level");
        wr(5'h0C, 32'h1);
        chk_oe(1'b0, "R3 hiz releases");
        wr(5'h0C, 32'h0);
        wr(5'h10, 32'h0);
        chk_out(1'b0, "R3 out low");
        wr(5'h00, 32'h02);
        chk_oe(1'b0, "R13 disabled no drive");
        wr(5'h00, 32'h01);
        chk_oe(1'b0, "R3 input dir");

        // R4 latency through the input path
        set_pad(1'b1);
        reg_addr = 5'h08;
        repeat (2) @(posedge clk);
        chk_rd(5'h08, 32'h0, "R4 not yet after two edges");
        @(posedge clk);
        chk_rd(5'h08, 32'h1, "R4 visible after three edges");

        // R10 type none
        wr(5'h00, 32'h41);
        set_pad(1'b0); settle(); set_pad(1'b1); settle(); set_pad(1'b0); settle();
        chk_rd(5'h14, 32'h0, "R10 no pending");

        // R8 rising
        wr(5'h00, 32'h59);
        set_pad(1'b1); settle();
        chk_irq(1'b1, "R8 rising pends");
        clr();
        chk_irq(1'b0, "R11 clear");
        set_pad(1'b0); settle();
        chk_irq(1'b0, "R8 falling ignored in rising mode");
        // R8 falling
        wr(5'h00, 32'h49);
        set_pad(1'b1); settle();
        chk_irq(1'b0, "R8 rising ignored in falling mode");
        set_pad(1'b0); settle();
        chk_irq(1'b1, "R8 falling pends");
        clr();

        // R12 mask keeps pending
        wr(5'h00, 32'h19);
        set_pad(1'b1); settle();
        chk_irq(1'b0, "R12 masked");
        chk_rd(5'h14, 32'h1, "R12 pending kept");
        wr(5'h00, 32'h59);
        chk_irq(1'b1, "R12 unmasked");
        clr();

        // R9 both edges, polarity ignored
        wr(5'h00, 32'h4D);
        set_pad(1'b0); settle();
        chk_irq(1'b1, "R9 fall pol0");
        clr();
        set_pad(1'b1); settle();
        chk_irq(1'b1, "R9 rise pol0");
        clr();
        wr(5'h00, 32'h5D);
        set_pad(1'b0); settle();
        chk_irq(1'b1, "R9 fall pol1");
        // R11 clear coincident with a new edge: pending already set
        set_pad(1'b1);
        repeat (3) @(posedge clk);
        clr();
        chk_rd(5'h14, 32'h1, "R11 event beats clear");
        clr();
        chk_rd(5'h14, 32'h0, "R11 plain clear");

        // R7 level high (pad is high)
        wr(5'h00, 32'h55);
        @(negedge clk);
        chk_irq(1'b1, "R7 level high pends");
        clr();
        chk_irq(1'b1, "R11 level reasserts");
        set_pad(1'b0); settle(); clr();
        chk_irq(1'b0, "R7 inactive level cleared");
        wr(5'h00, 32'h45);
        @(negedge clk);
        chk_irq(1'b1, "R7 level low pends");
        set_pad(1'b1); settle(); clr();
        chk_irq(1'b0, "R7 level low inactive");

        // R13 disabled pin ignores activity
        wr(5'h00, 32'h5C);
        set_pad(1'b0); settle(); set_pad(1'b1); settle();
        wr(5'h00, 32'h5D);
        chk_rd(5'h14, 32'h0, "R13 no pending while disabled");
        chk_irq(1'b0, "R13 irq low");
        wr(5'h00, 32'h01);
        set_pad(1'b0); settle();

        // R5 debounce with threshold 3
        wr(5'h04, 32'h3);
        wr(5'h00, 32'h21);
        set_pad(1'b1); settle();
        tick(); tick();
        chk_rd(5'h08, 32'h0, "R5 two ticks not enough");
        set_pad(1'b0); settle();
        set_pad(1'b1); settle();
        tick(); tick();
        chk_rd(5'h08, 32'h0, "R5 glitch restarted count");
        tick();
        chk_rd(5'h08, 32'h1, "R5 accepted on third tick");

        // R6 zero threshold bypasses
        wr(5'h04, 32'h0);
        set_pad(1'b0);
        reg_addr = 5'h08;
        repeat (2) @(posedge clk);
        chk_rd(5'h08, 32'h1, "R6 old level after two edges");
        @(posedge clk);
        chk_rd(5'h08, 32'h0, "R6 bypass latency");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule